// File: doc/BRIEF.md
# Round-Key Expander for a 192-bit ARX Cipher Key

This block turns a 192-bit master key into the 28 round keys that a 128-bit add-rotate-xor block cipher consumes, one round key per accepted transfer. It keeps six 32-bit running state words and a round counter. For every round each word is combined with one of six fixed constants. The constant is picked by the round number modulo 6 and rotated according to the round number and the word position. The word is then rotated by its own fixed amount. The six updated words together form that round's key.

A pulse on the start input loads the master key. The first round key appears on a valid/ready stream output one cycle later. The consumer (normally the round datapath) takes one key per cycle while it holds ready high. When it lowers ready, the key and its round index are held unchanged until ready returns. Once round 27 has been taken, valid falls and a one-cycle done pulse is raised. A start that arrives while keys are still being offered is ignored.

Top module: `lea_ks_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `rk_valid_o` and `done_o` are 0. An asynchronous reset in the middle of a run clears `rk_valid_o`.
- R2: When `start_i` is 1 and `rk_valid_o` is 0 at a rising edge, the next cycle shows `rk_valid_o`=1 and `rk_idx_o`=0. The key carries round 0, computed from `mkey_i` as sampled at that edge. Master word k is `mkey_i[32k+31:32k]`.
- R3: For round j and word k (k = 0..5), the new word is rotl(prev[k] + rotl(C[j mod 6], (j+k) mod 32), S[k]). The addition is modulo 2^32, with S = 1, 3, 6, 11, 13, 17 and C = c3efe9db, 44626b02, 79e27c8a, 78df30ec, 715ea49e, c785da0a (hex). prev is the master key for j=0 and the round j-1 words otherwise. Word k of round key j is on `rk_data_o[32k+31:32k]`.
- R4: Each transfer (`rk_valid_o` and `rk_ready_i` both 1 at an edge) with index below 27 advances `rk_idx_o` by exactly one in the next cycle. With ready held high, one new key appears every cycle.
- R5: While `rk_valid_o` is 1 and `rk_ready_i` is 0, `rk_data_o` and `rk_idx_o` hold their values in the next cycle.
- R6: A transfer of index 27 makes `rk_valid_o` 0 and `done_o` 1 in the next cycle. `done_o` is 1 for one cycle only.
- R7: A `start_i` pulse while `rk_valid_o` is 1 is ignored: the keys and indices offered afterwards are those of the run already in progress.
- R8: Constant rotation amounts wrap modulo 32. For round 27, word 5 uses an unrotated constant.
- R9: `rk_idx_o` never exceeds 27 while `rk_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Loads the master key and begins a run when idle |
| mkey_i | input | 192 | Master key, word k at bits 32k+31:32k |
| rk_ready_i | input | 1 | Consumer accepts the current round key |
| rk_valid_o | output | 1 | A round key is offered |
| rk_data_o | output | 192 | Round key, word k at bits 32k+31:32k |
| rk_idx_o | output | 5 | Round index of the offered key |
| done_o | output | 1 | One-cycle pulse after the last round key is taken |

## Verification
Every round key feeds the next, so a wrong state word, constant choice or rotation amount corrupts the key it first touches and every later key of the run. The error therefore shows on `rk_data_o` at the first faulty round, at the latest one cycle after that round is loaded. A counter or constant-index slip shows either as a wrong `rk_idx_o` in the same cycle or as a key mismatch in the round where the constant choice diverges. Control faults show as a key that changes under back-pressure, a run that a stray start restarts, or a missing or extra done pulse right after index 27.

// File: rtl/lea_ks_pkg.sv
package lea_ks_pkg;

  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 6;
  localparam int KEY_W     = WORD_W * NUM_WORDS;
  localparam int NUM_CONST = 6;

  typedef logic [WORD_W-1:0] word_t;

  // Round constants, selected by round number modulo NUM_CONST
  localparam word_t KS_CONST [NUM_CONST] = '{
    32'hc3efe9db, 32'h44626b02, 32'h79e27c8a,
    32'h78df30ec, 32'h715ea49e, 32'hc785da0a
  };

  // Final per-word left rotation
  localparam int KS_ROT [NUM_WORDS] = '{1, 3, 6, 11, 13, 17};

  function automatic word_t rotl(input word_t x, input int unsigned s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << (s % WORD_W);
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

endpackage

// File: rtl/lea_ks_word.sv
module lea_ks_word
  import lea_ks_pkg::*;
#(
  parameter int WORD_POS = 0,
  parameter int ROT_AMT  = 1,
  parameter int IDX_W    = 5
) (
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] const_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] word_o
);

  int unsigned  pre_amt;
  logic [WORD_W-1:0] pre_c;
  logic [WORD_W-1:0] sum;

  always_comb begin
    pre_amt = (int'(ridx_i) + WORD_POS) % WORD_W;
    pre_c   = rotl(const_i, pre_amt);
    sum     = src_i + pre_c;
    word_o  = rotl(sum, ROT_AMT);
  end

endmodule

// File: rtl/lea_ks_ctrl.sv
module lea_ks_ctrl
  import lea_ks_pkg::*;
#(
  parameter int NUM_ROUNDS = 28,
  localparam int IDX_W     = $clog2(NUM_ROUNDS),
  localparam int SEL_W     = $clog2(NUM_CONST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             load_o,
  output logic [IDX_W-1:0] nxt_idx_o,
  output logic [SEL_W-1:0] nxt_sel_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_CONST - 1);

  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] sel_q;
  logic             done_q;
  logic             take_start;
  logic             take_step;
  logic             take_last;

  always_comb begin
    take_start = start_i && !valid_q;
    take_step  = valid_q && ready_i && (idx_q != LAST_IDX);
    take_last  = valid_q && ready_i && (idx_q == LAST_IDX);
    load_o     = take_start || take_step;
    nxt_idx_o  = valid_q ? idx_q + 1'b1 : '0;
    if (!valid_q)               nxt_sel_o = '0;
    else if (sel_q == LAST_SEL) nxt_sel_o = '0;
    else                        nxt_sel_o = sel_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      sel_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= take_last;
      if (take_start)     valid_q <= 1'b1;
      else if (take_last) valid_q <= 1'b0;
      if (load_o) begin
        idx_q <= nxt_idx_o;
        sel_q <= nxt_sel_o;
      end
    end
  end

  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign done_o  = done_q;

endmodule

// File: rtl/lea_ks_gen.sv
module lea_ks_gen
  import lea_ks_pkg::*;
#(
  parameter int NUM_ROUNDS = 28,
  localparam int IDX_W     = $clog2(NUM_ROUNDS),
  localparam int SEL_W     = $clog2(NUM_CONST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [KEY_W-1:0] mkey_i,
  input  logic             rk_ready_i,
  output logic             rk_valid_o,
  output logic [KEY_W-1:0] rk_data_o,
  output logic [IDX_W-1:0] rk_idx_o,
  output logic             done_o
);

  logic             load;
  logic [IDX_W-1:0] nxt_idx;
  logic [SEL_W-1:0] nxt_sel;
  logic [KEY_W-1:0] key_q;
  logic [KEY_W-1:0] key_src;
  logic [KEY_W-1:0] key_nxt;
  logic [WORD_W-1:0] cur_const;

  lea_ks_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_i   (rk_ready_i),
    .valid_o   (rk_valid_o),
    .idx_o     (rk_idx_o),
    .load_o    (load),
    .nxt_idx_o (nxt_idx),
    .nxt_sel_o (nxt_sel),
    .done_o    (done_o)
  );

  // Source is the master key for round 0, otherwise the held round key
  assign key_src   = rk_valid_o ? key_q : mkey_i;
  assign cur_const = KS_CONST[nxt_sel];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    lea_ks_word #(
      .WORD_POS (k),
      .ROT_AMT  (KS_ROT[k]),
      .IDX_W    (IDX_W)
    ) i_word (
      .src_i   (key_src[k*WORD_W +: WORD_W]),
      .const_i (cur_const),
      .ridx_i  (nxt_idx),
      .word_o  (key_nxt[k*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    key_q <= '0;
    else if (load) key_q <= key_nxt;
  end

  assign rk_data_o = key_q;

endmodule

// File: rtl/lea_ks_chk.sv
module lea_ks_chk
  import lea_ks_pkg::*;
#(
  parameter int NUM_ROUNDS = 28,
  localparam int IDX_W     = $clog2(NUM_ROUNDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             rk_ready_i,
  input logic             rk_valid_o,
  input logic [KEY_W-1:0] rk_data_o,
  input logic [IDX_W-1:0] rk_idx_o,
  input logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ROUNDS - 1);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !rk_valid_o) |=> (rk_valid_o && rk_idx_o == '0));

  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && rk_ready_i && rk_idx_o != LAST_IDX)
      |=> (rk_valid_o && rk_idx_o == $past(rk_idx_o) + 1'b1));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && !rk_ready_i)
      |=> (rk_valid_o && $stable(rk_data_o) && $stable(rk_idx_o)));

  p_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && rk_ready_i && rk_idx_o == LAST_IDX) |=> (!rk_valid_o && done_o));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rk_valid_o && start_i && !rk_ready_i) |=> (rk_idx_o == $past(rk_idx_o)));

  p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rk_valid_o |-> (rk_idx_o <= LAST_IDX));

endmodule

bind lea_ks_gen lea_ks_chk #(.NUM_ROUNDS(NUM_ROUNDS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .rk_ready_i (rk_ready_i),
  .rk_valid_o (rk_valid_o),
  .rk_data_o  (rk_data_o),
  .rk_idx_o   (rk_idx_o),
  .done_o     (done_o)
);

// File: tb/test_lea_ks_gen.sv
`timescale 1ns/1ps
module test_lea_ks_gen;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [191:0] mkey_i = '0;
  logic         rk_ready_i = 1'b0;
  logic         rk_valid_o;
  logic [191:0] rk_data_o;
  logic [4:0]   rk_idx_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;
  logic [191:0] exp_rk [28];

  always #4 clk = ~clk;

  lea_ks_gen i_lea_ks_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mkey_i     (mkey_i),
    .rk_ready_i (rk_ready_i),
    .rk_valid_o (rk_valid_o),
    .rk_data_o  (rk_data_o),
    .rk_idx_o   (rk_idx_o),
    .done_o     (done_o)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    int m;
    m = n % 32;
    if (m == 0) return v;
    return (v << m) | (v >> (32 - m));
  endfunction

  // Reference round keys from R3 / R8
  task automatic build_model(input logic [191:0] mk);
    logic [31:0] cst [6];
    int          sh  [6];
    logic [31:0] st  [6];
    cst = '{32'hc3efe9db, 32'h44626b02, 32'h79e27c8a,
            32'h78df30ec, 32'h715ea49e, 32'hc785da0a};
    sh  = '{1, 3, 6, 11, 13, 17};
    for (int k = 0; k < 6; k++) st[k] = mk[32*k +: 32];
    for (int j = 0; j < 28; j++) begin
      for (int k = 0; k < 6; k++) begin
        st[k] = rl(st[k] + rl(cst[j % 6], j + k), sh[k]);
        exp_rk[j][32*k +: 32] = st[k];
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_round(input int j, input string req);
    chk(rk_valid_o == 1'b1, req, "valid", 192'(rk_valid_o), 192'd1);
    chk(rk_idx_o == 5'(j), req, "index", 192'(rk_idx_o), 192'(j));
    chk(rk_data_o == exp_rk[j], req, "round key", rk_data_o, exp_rk[j]);
  endtask

  task automatic check_end(input string req);
    chk(rk_valid_o == 1'b0, req, "valid after last", 192'(rk_valid_o), 192'd0);
    chk(done_o == 1'b1, req, "done pulse", 192'(done_o), 192'd1);
    @(negedge clk);
    chk(done_o == 1'b0, req, "done one cycle", 192'(done_o), 192'd0);
  endtask

  task automatic t_reset;
    // R1: state during and right after reset
    rst_n = 1'b0;
    @(negedge clk);
    chk(rk_valid_o == 1'b0, "R1", "valid in reset", 192'(rk_valid_o), 192'd0);
    chk(done_o == 1'b0, "R1", "done in reset", 192'(done_o), 192'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rk_valid_o == 1'b0, "R1", "valid after reset", 192'(rk_valid_o), 192'd0);
  endtask

  // R2, R3, R4, R6, R8: full stream with ready held high
  task automatic t_stream(input logic [191:0] mk);
    build_model(mk);
    mkey_i = mk;
    start_i = 1'b1;
    rk_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    mkey_i = ~mk;
    for (int j = 0; j < 28; j++) begin
      check_round(j, (j == 0) ? "R2" : ((j == 27) ? "R8" : "R3"));
      @(negedge clk);
    end
    check_end("R6");
  endtask

  // R5: back-pressure holds key and index
  task automatic t_backpressure(input logic [191:0] mk);
    int j = 0;
    int cyc = 0;
    bit r;
    build_model(mk);
    mkey_i = mk;
    start_i = 1'b1;
    rk_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (j < 28) begin
      check_round(j, "R5");
      r = (cyc >= 3) && (cyc % 4 != 1);
      rk_ready_i = r;
      if (r) j++;
      cyc++;
      @(negedge clk);
    end
    check_end("R6");
  endtask

  // R7: start while busy is ignored
  task automatic t_ignore_start(input logic [191:0] mk, input logic [191:0] other);
    build_model(mk);
    mkey_i = mk;
    start_i = 1'b1;
    rk_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int j = 0; j < 28; j++) begin
      check_round(j, "R7");
      if (j >= 5 && j <= 8) begin
        start_i = 1'b1;
        mkey_i = other;
        rk_ready_i = (j != 6);
      end else begin
        start_i = 1'b0;
        rk_ready_i = 1'b1;
      end
      @(negedge clk);
      if (j == 6) begin
        check_round(6, "R7");
        rk_ready_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
      end
    end
    start_i = 1'b0;
    check_end("R6");
  endtask

  // R1: reset mid-run
  task automatic t_reset_mid(input logic [191:0] mk);
    build_model(mk);
    mkey_i = mk;
    start_i = 1'b1;
    rk_ready_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(rk_valid_o == 1'b0, "R1", "valid after mid-run reset", 192'(rk_valid_o), 192'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_stream(192'h000102030405060708090a0b0c0d0e0f1011121314151617);
    t_stream(192'h0);
    t_stream({192{1'b1}});
    t_backpressure(192'h0f1e2d3c4b5a69788796a5b4c3d2e1f00123456789abcdef);
    t_ignore_start(192'hfedcba98765432100011223344556677_8899aabbccddeeff,
                   192'h5555aaaa5555aaaa5555aaaa5555aaaa5555aaaa5555aaaa);
    t_reset_mid(192'h1);
    t_stream(192'h243f6a8885a308d313198a2e03707344a4093822299f31d0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule